// File: doc/BRIEF.md
# Dual-Path Masked Interrupt Controller

This block collects up to 32 level-sensitive interrupt sources and drives two processor-facing request lines from them: a normal request and a fast request. Each source is the OR of an external input line and a software-set latch. Two independent enable masks, one per request line, select which pending sources reach each line. Each line is the registered OR of its masked pending bits. A third word, the pass-through enable, forwards chosen raw sources straight out to a parent controller on a separate 32-bit output.

Software works through a plain 32-bit register port: an address, a write strobe, write data and read data. Read data is combinational and follows the address in the same cycle. Every enable and the soft latch are changed only by write-one-to-set and write-one-to-clear words, so zero bits in a written word leave state alone. An instance parameter marks which sources exist. A source that is not marked can never pend, be enabled or be forwarded. This port is a control path with no data stream, so it has no valid/ready handshake and never stalls.

Top module: `dual_path_intc`

## Requirements
- R1: After reset, both enable masks, the soft latch and the pass-through enable are zero; `irq_out`, `fiq_out` and `pass_out` are low, and every readable offset returns zero while all inputs are low.
- R2: A write to 0x08 sets the normal-path enable for each 1 bit, and a write to 0x0C clears the enable for each 1 bit. Zero bits leave their enables unchanged. A read of 0x08 returns the normal-path enable mask.
- R3: A write to 0x28 sets and a write to 0x2C clears the fast-path enables in the same way. A read of 0x28 returns the fast-path enable mask. Writes to either path leave the other path's mask unchanged.
- R4: A read of 0x04 or of 0x24 returns the raw pending word: bit n is the input OR the soft latch for source n.
- R5: A read of 0x00 returns raw AND the normal enable mask. A read of 0x20 returns raw AND the fast enable mask.
- R6: A write to 0x10 sets soft-latch bits and a write to 0x14 clears them. A read of 0x10 returns the latch. If set and clear both reach a bit in the same cycle, the bit is cleared.
- R7: Sources are levels: a masked pending bit follows its input and drops as soon as the input and the soft bit are both low.
- R8: `irq_out` (`fiq_out`) equals the OR of the normal (fast) masked word one clock earlier.
- R9: A write to 0x20 loads the whole pass-through enable word. `pass_out` is raw AND that word, combinationally. A write to 0x20 leaves the fast enable mask unchanged.
- R10: Sources not marked in the `VALID` parameter read as zero in every word, never become enabled or latched, and never reach any output.
- R11: Reads of unmapped or write-only offsets (0x0C, 0x14, 0x2C and all others not listed above) return zero. Writes to 0x00, 0x04, 0x24 and unmapped offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_i | input | 32 | Level interrupt inputs, one per source |
| irq_out | output | 1 | Normal interrupt request, registered |
| fiq_out | output | 1 | Fast interrupt request, registered |
| pass_out | output | 32 | Raw sources gated by the pass-through enable |

## Verification
A wrong enable or latch bit is visible on the read port in the cycle after the write that produced it: the readback of 0x08, 0x28 or 0x10 shows it directly, and the masked words at 0x00 and 0x20 show it once a source is driven. The request lines lag the state by exactly one clock, so a stuck or leaking enable shows on `irq_out` or `fiq_out` one edge after the source changes. A pass-through fault shows on `pass_out` with no delay. A write that reaches the wrong state is caught by reading back the state that the write should have left alone.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned BANKS = 3;
  localparam int unsigned BK_IRQ  = 0;
  localparam int unsigned BK_FIQ  = 1;
  localparam int unsigned BK_SOFT = 2;

  localparam logic [7:0] OFF_IRQ_MASKED = 8'h00;
  localparam logic [7:0] OFF_RAW_A      = 8'h04;
  localparam logic [7:0] OFF_IRQ_SET    = 8'h08;
  localparam logic [7:0] OFF_IRQ_CLR    = 8'h0C;
  localparam logic [7:0] OFF_SOFT_SET   = 8'h10;
  localparam logic [7:0] OFF_SOFT_CLR   = 8'h14;
  localparam logic [7:0] OFF_FIQ_MASKED = 8'h20;
  localparam logic [7:0] OFF_PASS_LOAD  = 8'h20;
  localparam logic [7:0] OFF_RAW_B      = 8'h24;
  localparam logic [7:0] OFF_FIQ_SET    = 8'h28;
  localparam logic [7:0] OFF_FIQ_CLR    = 8'h2C;

  function automatic logic [7:0] set_offset(input int unsigned bank);
    case (bank)
      BK_IRQ:  set_offset = OFF_IRQ_SET;
      BK_FIQ:  set_offset = OFF_FIQ_SET;
      default: set_offset = OFF_SOFT_SET;
    endcase
  endfunction

  function automatic logic [7:0] clr_offset(input int unsigned bank);
    case (bank)
      BK_IRQ:  clr_offset = OFF_IRQ_CLR;
      BK_FIQ:  clr_offset = OFF_FIQ_CLR;
      default: clr_offset = OFF_SOFT_CLR;
    endcase
  endfunction
endpackage

// File: rtl/irqc_bitbank.sv
module irqc_bitbank #(
  parameter int unsigned N = 32,
  parameter logic [N-1:0] VALID = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q_next;

  // clear wins over set; unimplemented bits never hold a 1
  always_comb q_next = (q_o | set_i) & ~clr_i & VALID;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= q_next;
  end

  // R2, R3, R6: a set bit that is not also cleared is held next cycle
  p_set_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    |(set_i & ~clr_i & VALID) |=>
      ((q_o & $past(set_i & ~clr_i & VALID)) == $past(set_i & ~clr_i & VALID)));

  // R6: clear has priority over set on the same bit
  p_clear_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    |clr_i |=> ((q_o & $past(clr_i)) == '0));

  // R2: bits named by neither word keep their value
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q_o & ~$past(set_i | clr_i)) == ($past(q_o) & ~$past(set_i | clr_i))));

  // R10: unimplemented bits stay zero
  p_invalid_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o & ~VALID) == '0);
endmodule

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int unsigned N = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic                   wr_i,
  input  logic [N-1:0]           wdata_i,
  input  logic [N-1:0]           raw_i,
  input  logic [N-1:0]           irq_masked_i,
  input  logic [N-1:0]           fiq_masked_i,
  input  logic [BANKS-1:0][N-1:0] bank_q_i,
  output logic [BANKS-1:0][N-1:0] set_o,
  output logic [BANKS-1:0][N-1:0] clr_o,
  output logic                   pass_load_o,
  output logic [N-1:0]           rdata_o
);
  for (genvar b = 0; b < BANKS; b++) begin : g_strobe
    localparam logic [7:0] SOFF = set_offset(b);
    localparam logic [7:0] COFF = clr_offset(b);
    assign set_o[b] = (wr_i && addr_i == ADDR_W'(SOFF)) ? wdata_i : '0;
    assign clr_o[b] = (wr_i && addr_i == ADDR_W'(COFF)) ? wdata_i : '0;

    // R11: only one register is written per access
    p_one_target_r11: assert final (!((|set_o[b]) && (|clr_o[b])));
  end

  assign pass_load_o = wr_i && (addr_i == ADDR_W'(OFF_PASS_LOAD));

  always_comb begin
    rdata_o = '0;
    if      (addr_i == ADDR_W'(OFF_IRQ_MASKED)) rdata_o = irq_masked_i;
    else if (addr_i == ADDR_W'(OFF_RAW_A))      rdata_o = raw_i;
    else if (addr_i == ADDR_W'(OFF_IRQ_SET))    rdata_o = bank_q_i[BK_IRQ];
    else if (addr_i == ADDR_W'(OFF_SOFT_SET))   rdata_o = bank_q_i[BK_SOFT];
    else if (addr_i == ADDR_W'(OFF_FIQ_MASKED)) rdata_o = fiq_masked_i;
    else if (addr_i == ADDR_W'(OFF_RAW_B))      rdata_o = raw_i;
    else if (addr_i == ADDR_W'(OFF_FIQ_SET))    rdata_o = bank_q_i[BK_FIQ];
  end
endmodule

// File: rtl/irqc_outreg.sv
module irqc_outreg #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_masked_i,
  input  logic [N-1:0] fiq_masked_i,
  output logic         irq_o,
  output logic         fiq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      irq_o <= |irq_masked_i;
      fiq_o <= |fiq_masked_i;
    end
  end

  // R8: each request line trails its masked word by one clock
  p_irq_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_masked_i) |=> irq_o);
  p_fiq_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(|fiq_masked_i) |=> !fiq_o);
endmodule

// File: rtl/dual_path_intc.sv
module dual_path_intc
  import irqc_pkg::*;
#(
  parameter int unsigned N = 32,
  parameter int unsigned ADDR_W = 8,
  parameter logic [N-1:0] VALID = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [N-1:0]      bus_wdata,
  output logic [N-1:0]      bus_rdata,
  input  logic [N-1:0]      src_i,
  output logic              irq_out,
  output logic              fiq_out,
  output logic [N-1:0]      pass_out
);
  logic [BANKS-1:0][N-1:0] set_w, clr_w, bank_q;
  logic [N-1:0] raw, irq_masked, fiq_masked, pass_q;
  logic         pass_load;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    irqc_bitbank #(.N(N), .VALID(VALID)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .set_i(set_w[b]), .clr_i(clr_w[b]), .q_o(bank_q[b])
    );
  end

  always_comb begin
    raw        = (src_i & VALID) | bank_q[BK_SOFT];
    irq_masked = raw & bank_q[BK_IRQ];
    fiq_masked = raw & bank_q[BK_FIQ];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pass_q <= '0;
    else if (pass_load) pass_q <= bus_wdata & VALID;
  end

  assign pass_out = raw & pass_q;

  irqc_decode #(.N(N), .ADDR_W(ADDR_W)) u_dec (
    .addr_i(bus_addr), .wr_i(bus_wr), .wdata_i(bus_wdata),
    .raw_i(raw), .irq_masked_i(irq_masked), .fiq_masked_i(fiq_masked),
    .bank_q_i(bank_q), .set_o(set_w), .clr_o(clr_w),
    .pass_load_o(pass_load), .rdata_o(bus_rdata)
  );

  irqc_outreg #(.N(N)) u_out (
    .clk(clk), .rst_n(rst_n),
    .irq_masked_i(irq_masked), .fiq_masked_i(fiq_masked),
    .irq_o(irq_out), .fiq_o(fiq_out)
  );

  // R9: a pass-through load never disturbs the fast enable mask
  p_pass_keeps_fiq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_load && !(|set_w[BK_FIQ]) && !(|clr_w[BK_FIQ])) |=> $stable(bank_q[BK_FIQ]));

  // R10: unimplemented sources never leave the block
  p_pass_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_out & ~VALID) == '0);
endmodule

// File: tb/dual_path_intc_test.sv
`timescale 1ns/1ps
module dual_path_intc_test;
  localparam logic [31:0] V = 32'hFFF7_FFFE;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] src_i = '0;
  logic        irq_out, fiq_out;
  logic [31:0] pass_out;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dual_path_intc #(.N(32), .ADDR_W(8), .VALID(V)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_i(src_i),
    .irq_out(irq_out), .fiq_out(fiq_out), .pass_out(pass_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #0.5;
    chk(req, bus_rdata, exp);
  endtask

  task automatic drive_src(input logic [31:0] s);
    @(negedge clk);
    src_i = s;
  endtask

  task automatic t_reset;
    rd_chk("R1 masked irq", 8'h00, 0);
    rd_chk("R1 raw", 8'h04, 0);
    rd_chk("R1 irq enable", 8'h08, 0);
    rd_chk("R1 soft", 8'h10, 0);
    rd_chk("R1 fiq enable", 8'h28, 0);
    chk("R1 irq_out", {31'b0, irq_out}, 0);
    chk("R1 fiq_out", {31'b0, fiq_out}, 0);
    chk("R1 pass_out", pass_out, 0);
  endtask

  task automatic t_irq_enable;
    wr(8'h08, 32'h0000_00F0); rd_chk("R2 set", 8'h08, 32'h0000_00F0);
    wr(8'h08, 32'h0000_0100); rd_chk("R2 set keeps others", 8'h08, 32'h0000_01F0);
    wr(8'h0C, 32'h0000_0030); rd_chk("R2 clear", 8'h08, 32'h0000_01C0);
    wr(8'h0C, 32'h0000_0000); rd_chk("R2 zero clear", 8'h08, 32'h0000_01C0);
  endtask

  task automatic t_fiq_enable;
    wr(8'h28, 32'h8000_0002); rd_chk("R3 set", 8'h28, 32'h8000_0002);
    wr(8'h2C, 32'h0000_0002); rd_chk("R3 clear", 8'h28, 32'h8000_0000);
    rd_chk("R3 irq mask untouched", 8'h08, 32'h0000_01C0);
  endtask

  task automatic t_soft;
    wr(8'h10, 32'h0000_1004); rd_chk("R6 soft set", 8'h10, 32'h0000_1004);
    rd_chk("R4 raw A", 8'h04, 32'h0000_1004);
    rd_chk("R4 raw B", 8'h24, 32'h0000_1004);
    wr(8'h14, 32'h0000_0004); rd_chk("R6 soft clear", 8'h10, 32'h0000_1000);
    rd_chk("R4 raw after clear", 8'h04, 32'h0000_1000);
  endtask

  task automatic t_masked;
    drive_src(32'h0000_0040);
    rd_chk("R4 raw with input", 8'h04, 32'h0000_1040);
    rd_chk("R5 irq masked", 8'h00, 32'h0000_0040);
    rd_chk("R5 fiq masked", 8'h20, 32'h0000_0000);
    drive_src(32'h0);
    rd_chk("R7 level drops", 8'h00, 32'h0000_0000);
    drive_src(32'h8000_0000);
    rd_chk("R5 fiq masked src31", 8'h20, 32'h8000_0000);
    drive_src(32'h0);
    rd_chk("R7 fiq level drops", 8'h20, 32'h0000_0000);
  endtask

  task automatic t_outputs;
    wr(8'h0C, 32'hFFFF_FFFF); wr(8'h2C, 32'hFFFF_FFFF); wr(8'h14, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R8 irq idle", {31'b0, irq_out}, 0);
    wr(8'h08, 32'h0000_0008);
    src_i = 32'h0000_0008;
    #0.5;
    chk("R8 irq not yet", {31'b0, irq_out}, 0);
    @(negedge clk);
    chk("R8 irq after one edge", {31'b0, irq_out}, 1);
    chk("R8 fiq stays low", {31'b0, fiq_out}, 0);
    wr(8'h28, 32'h0000_0008);
    chk("R8 fiq not yet", {31'b0, fiq_out}, 0);
    @(negedge clk);
    chk("R8 fiq after one edge", {31'b0, fiq_out}, 1);
    src_i = 32'h0;
    @(negedge clk);
    chk("R7 irq falls", {31'b0, irq_out}, 0);
    chk("R7 fiq falls", {31'b0, fiq_out}, 0);
  endtask

  task automatic t_pass;
    wr(8'h20, 32'hFFD0_0000);
    src_i = 32'h0050_0000;
    #0.5;
    chk("R9 pass sources 20,22", pass_out, 32'h0050_0000);
    src_i = 32'h0020_0000;
    #0.5;
    chk("R9 pass blocks 21", pass_out, 32'h0);
    rd_chk("R9 fiq mask kept", 8'h28, 32'h0000_0008);
    src_i = 32'h0;
  endtask

  task automatic t_invalid;
    wr(8'h08, 32'h0008_0001); rd_chk("R10 enable invalid", 8'h08, 32'h0000_0008);
    wr(8'h10, 32'h0008_0001); rd_chk("R10 soft invalid", 8'h10, 32'h0);
    wr(8'h20, 32'hFFFF_FFFF);
    src_i = 32'h0008_0001;
    rd_chk("R10 raw invalid", 8'h04, 32'h0);
    chk("R10 pass invalid", pass_out, 32'h0);
    src_i = 32'h0;
  endtask

  task automatic t_unmapped;
    rd_chk("R11 read 0x0C", 8'h0C, 0);
    rd_chk("R11 read 0x2C", 8'h2C, 0);
    rd_chk("R11 read 0x18", 8'h18, 0);
    rd_chk("R11 read 0x40", 8'h40, 0);
    wr(8'h00, 32'hFFFF_FFFF); wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h24, 32'hFFFF_FFFF); wr(8'h18, 32'hFFFF_FFFF);
    rd_chk("R11 irq mask kept", 8'h08, 32'h0000_0008);
    rd_chk("R11 fiq mask kept", 8'h28, 32'h0000_0008);
    rd_chk("R11 soft kept", 8'h10, 32'h0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_irq_enable();
    t_fiq_enable();
    t_soft();
    t_masked();
    t_outputs();
    t_pass();
    t_invalid();
    t_unmapped();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule